// File: doc/BRIEF.md
# Command-Driven Test Stream Controller

This block sits between a host command channel and a byte-wide transmit path. The host sends one ASCII byte at a time. The block uses these bytes to bring a test data source up, start it, pause it, shut it down or reset it. A small phase machine moves through Reset, Configure and Wait before any data may flow. Data flows only in the Transfer phase, and only after a start command has been seen.

The data source is a built-in pattern generator. It alternates two 24-bit words and sends each one as three bytes, most significant byte first, over a valid/ready handshake. Words are never split. A stop takes effect only once the word in flight has gone out. After a stop and restart, the pattern carries on where it left off. After a reset, the pattern begins again with its first word.

The current phase is exposed on its own port so that the host side can follow the bring-up sequence.

Top module: `acq_stream_ctrl`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `phase` reads Reset and `out_valid` is low. Phase codes: 0 = Reset, 1 = Configure, 2 = Wait, 3 = Transfer.
- R2: After leaving reset, Reset lasts one cycle. Configure then lasts exactly `CFG_CYC` cycles, after which the phase becomes Wait.
- R3: Wait lasts at least `WAIT_CYC` cycles. If no start is pending, the block stays in Wait with `out_valid` low.
- R4: A start byte 0x73 ('s') sets a pending start in any phase. Transfer is entered on the first cycle that both the pending start and the elapsed Wait time allow.
- R5: In Transfer the bytes 0x06, 0x12, 0x22, 0x20, 0x00, 0x00 are sent in that order and repeated without end. These are the words 0x061222 and 0x200000, each sent most significant byte first.
- R6: `out_valid` is high in every Transfer cycle and low in every other phase. A byte is consumed only when `out_valid` and `out_ready` are both high. While stalled, `out_data` holds its value.
- R7: A stop byte 0x74 ('t') lets the rest of the current word go out, then returns the block to Wait with no further bytes. A stop that arrives in the same cycle as the handshake of a word's last byte ends the transfer right at that boundary.
- R8: A start after a stop resumes Transfer on the next cycle, without repeating Wait. The first byte is the one that follows the last byte sent.
- R9: A reset byte 0x72 ('r') puts the block in Reset on the next cycle from any phase. This holds mid-word and after a quit. The full Configure/Wait sequence runs again, and the pattern restarts at 0x06.
- R10: A quit byte 0x71 ('q') stops like 't'. After it, the bytes 's', 't' and 'q' have no effect until an 'r' arrives.
- R11: Any other byte value, and any value on `cmd_data` while `cmd_valid` is low, has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command byte present this cycle |
| cmd_data | input | 8 | ASCII command byte |
| out_valid | output | 1 | Transmit byte available |
| out_ready | input | 1 | Transmit side accepts the byte |
| out_data | output | 8 | Transmit byte |
| phase | output | 2 | Current phase (0 Reset, 1 Configure, 2 Wait, 3 Transfer) |

## Verification
The hardest overlap is a stop command that lands in the same cycle as the handshake of the last byte of a word. In that cycle the byte is consumed, the pattern moves to its next word, and the block must leave Transfer, all on one edge. The bench waits until the third byte of a word is on the port with `out_ready` high. It then drives 't' in that same cycle. It expects `out_valid` low on the next cycle, the stream position on a word boundary, and no further bytes afterwards. A reset command that coincides with a byte handshake in mid-word is provoked the same way. For that case the bench expects Reset on the next cycle and 0x06 as the first byte of the next run.

// File: rtl/acq_stream_ctrl.sv
module acq_stream_ctrl #(
  parameter int          CFG_CYC  = 4,
  parameter int          WAIT_CYC = 3,
  parameter logic [23:0] WORD_A   = 24'h061222,
  parameter logic [23:0] WORD_B   = 24'h200000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [7:0] cmd_data,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic [1:0] phase
);

  localparam int CNT_MAX = (CFG_CYC > WAIT_CYC) ? CFG_CYC : WAIT_CYC;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam logic [CW-1:0] CFG_LAST  = CW'(CFG_CYC - 1);
  localparam logic [CW-1:0] WAIT_LAST = CW'(WAIT_CYC - 1);

  typedef enum logic [1:0] {PH_RST = 2'd0, PH_CFG = 2'd1, PH_WAIT = 2'd2, PH_XFER = 2'd3} phase_t;

  phase_t        ph_q;
  logic [CW-1:0] cnt_q;
  logic          run_q, quit_q, sel_q;
  logic [1:0]    idx_q;
  logic [23:0]   word;

  wire cmd_r  = cmd_valid && cmd_data == 8'h72;
  wire cmd_s  = cmd_valid && !quit_q && cmd_data == 8'h73;
  wire cmd_t  = cmd_valid && !quit_q && cmd_data == 8'h74;
  wire cmd_q  = cmd_valid && !quit_q && cmd_data == 8'h71;
  wire run_nx = cmd_s || (run_q && !cmd_t && !cmd_q);
  wire fire   = out_valid && out_ready;
  wire last   = idx_q == 2'd2;

  assign word      = sel_q ? WORD_B : WORD_A;
  assign out_valid = ph_q == PH_XFER;
  assign out_data  = (idx_q == 2'd0) ? word[23:16] :
                     (idx_q == 2'd1) ? word[15:8]  : word[7:0];
  assign phase     = ph_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_RST;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      quit_q <= 1'b0;
      sel_q  <= 1'b0;
      idx_q  <= 2'd0;
    end else if (cmd_r) begin
      ph_q   <= PH_RST;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      quit_q <= 1'b0;
      sel_q  <= 1'b0;
      idx_q  <= 2'd0;
    end else begin
      run_q <= run_nx;
      if (cmd_q) quit_q <= 1'b1;
      if (fire) begin
        idx_q <= last ? 2'd0 : idx_q + 2'd1;
        if (last) sel_q <= ~sel_q;
      end
      unique case (ph_q)
        PH_RST: begin
          ph_q  <= PH_CFG;
          cnt_q <= '0;
        end
        PH_CFG:
          if (cnt_q == CFG_LAST) begin
            ph_q  <= PH_WAIT;
            cnt_q <= '0;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        PH_WAIT:
          if (cnt_q == WAIT_LAST) begin
            if (run_nx) ph_q <= PH_XFER;
          end else begin
            cnt_q <= cnt_q + CW'(1);
          end
        PH_XFER:
          if (fire && last && !run_nx) ph_q <= PH_WAIT;
      endcase
    end
  end

endmodule

// File: rtl/acq_stream_ctrl_chk.sv
module acq_stream_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [7:0] cmd_data,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic [1:0] phase,
  input logic       quit
);

  logic cmd_rst;
  assign cmd_rst = cmd_valid && cmd_data == 8'h72;

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready && !cmd_rst |=> out_valid && $stable(out_data));

  // R9
  cmd_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_rst |=> phase == 2'd0 && !out_valid);

  // R2
  rst_to_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd0 && !cmd_rst |=> phase == 2'd1);

  // R3
  xfer_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 && $past(phase) != 2'd3 |-> $past(phase) == 2'd2);

  // R5
  byte_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_data inside {8'h06, 8'h12, 8'h22, 8'h20, 8'h00});

  // R7
  word_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    phase == 2'd3 && !cmd_rst && !(out_valid && out_ready) |=> phase == 2'd3);

  // R10
  quit_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    quit && phase != 2'd3 && !cmd_rst |=> phase != 2'd3);

endmodule

bind acq_stream_ctrl acq_stream_ctrl_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_data  (cmd_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .phase     (phase),
  .quit      (quit_q)
);

// File: tb/tb_acq_stream_ctrl.sv
module tb_acq_stream_ctrl;
  localparam int CFG = 4;
  localparam int WT  = 3;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_data = 8'h00;
  logic       out_ready = 1'b0;
  logic       out_valid;
  logic [7:0] out_data;
  logic [1:0] phase;

  int checks = 0, errors = 0, exp_idx = 0, nbytes = 0, cyc = 0;

  acq_stream_ctrl #(.CFG_CYC(CFG), .WAIT_CYC(WT)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .phase(phase)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    case (i)
      0: return 8'h06;
      1: return 8'h12;
      2: return 8'h22;
      3: return 8'h20;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      chk(out_data == pat(exp_idx), "R5", "stream byte", out_data, pat(exp_idx));
      exp_idx = (exp_idx + 1) % 6;
      nbytes++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      errors++;
      checks++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic send_cmd(logic [7:0] b);
    cmd_valid = 1'b1;
    cmd_data  = b;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_data  = 8'h00;
    if (b == 8'h72) exp_idx = 0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 10 && out_valid; k++) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase == 2'd0 && !out_valid, "R1", "reset state", {phase, out_valid}, 0);
    rst_n = 1'b1;
    exp_idx = 0;
  endtask

  task automatic t_sequence();
    int nr = 0, nc = 0;
    while (phase == 2'd0 && nr < 50) begin @(negedge clk); nr++; end
    chk(nr == 1, "R2", "reset cycles", nr, 1);
    while (phase == 2'd1 && nc < 50) begin @(negedge clk); nc++; end
    chk(nc == CFG, "R2", "configure cycles", nc, CFG);
    chk(phase == 2'd2, "R2", "phase after configure", phase, 2);
    repeat (20) @(negedge clk);
    chk(phase == 2'd2 && !out_valid, "R3", "idle wait without start", phase, 2);
    out_ready = 1'b1;
    send_cmd(8'h73);
    chk(phase == 2'd3 && out_valid, "R4", "start enters transfer", phase, 3);
  endtask

  task automatic t_stream();
    int n0 = nbytes;
    repeat (12) @(negedge clk);
    chk(nbytes - n0 == 12, "R6", "continuous bytes", nbytes - n0, 12);
  endtask

  task automatic t_backpressure();
    logic [7:0] d;
    int n0;
    out_ready = 1'b0;
    @(negedge clk);
    d  = out_data;
    n0 = nbytes;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == d, "R6", "stalled byte held", out_data, d);
    end
    chk(nbytes == n0, "R6", "no byte while stalled", nbytes - n0, 0);
    out_ready = 1'b1;
  endtask

  task automatic t_stop();
    int n0;
    while (exp_idx % 3 != 1) @(negedge clk);
    send_cmd(8'h74);
    wait_idle();
    chk(exp_idx % 3 == 0 && phase == 2'd2, "R7", "stop on word boundary", exp_idx, 0);
    n0 = nbytes;
    repeat (5) @(negedge clk);
    chk(nbytes == n0 && !out_valid, "R7", "no bytes after stop", nbytes - n0, 0);
    send_cmd(8'h73);
    chk(phase == 2'd3, "R8", "restart without wait", phase, 3);
    chk(out_data == pat(exp_idx), "R8", "pattern continues", out_data, pat(exp_idx));
  endtask

  task automatic t_coincide();
    int n0;
    while (!(out_valid && exp_idx % 3 == 2)) @(negedge clk);
    cmd_valid = 1'b1;
    cmd_data  = 8'h74;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!out_valid && phase == 2'd2, "R7", "stop on last byte", phase, 2);
    chk(exp_idx % 3 == 0, "R7", "boundary after coincident stop", exp_idx % 3, 0);
    n0 = nbytes;
    repeat (4) @(negedge clk);
    chk(nbytes == n0, "R7", "silent after coincident stop", nbytes - n0, 0);
    send_cmd(8'h73);
  endtask

  task automatic t_unknown();
    int n0 = nbytes;
    send_cmd(8'h41);
    cmd_data = 8'h74;
    repeat (5) @(negedge clk);
    cmd_data = 8'h00;
    chk(nbytes - n0 == 6 && phase == 2'd3, "R11", "stray bytes ignored in transfer", nbytes - n0, 6);
    send_cmd(8'h74);
    wait_idle();
    send_cmd(8'h53);
    repeat (5) @(negedge clk);
    chk(phase == 2'd2 && !out_valid, "R11", "stray byte does not start", phase, 2);
  endtask

  task automatic t_quit();
    send_cmd(8'h73);
    send_cmd(8'h71);
    wait_idle();
    chk(phase == 2'd2 && exp_idx % 3 == 0, "R10", "quit stops on boundary", exp_idx % 3, 0);
    send_cmd(8'h73);
    repeat (10) @(negedge clk);
    chk(!out_valid && phase == 2'd2, "R10", "start ignored after quit", phase, 2);
    send_cmd(8'h72);
    chk(phase == 2'd0 && !out_valid, "R9", "reset after quit", phase, 0);
  endtask

  task automatic t_reset_mid();
    int nw = 0;
    send_cmd(8'h73);
    while (phase != 2'd2) @(negedge clk);
    while (phase == 2'd2 && nw < 50) begin @(negedge clk); nw++; end
    chk(nw == WT, "R3", "wait cycles with pending start", nw, WT);
    chk(out_valid && out_data == 8'h06, "R9", "pattern restart", out_data, 8'h06);
    while (exp_idx % 3 != 1) @(negedge clk);
    send_cmd(8'h72);
    chk(phase == 2'd0 && !out_valid, "R9", "reset mid word", phase, 0);
    send_cmd(8'h73);
    while (phase != 2'd3) @(negedge clk);
    chk(out_data == 8'h06, "R9", "first byte after mid-word reset", out_data, 8'h06);
    repeat (6) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_sequence();
    t_stream();
    t_backpressure();
    t_stop();
    t_coincide();
    t_unknown();
    t_quit();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule